// File: doc/BRIEF.md
# Four-Mode Serial Transmitter

This block is the sending half of a small microcontroller-style serial port. A two-bit mode input selects one of four frame formats. Mode 0 is a synchronous shifter that puts eight data bits on the data line with a companion shift clock. Mode 1 is an asynchronous 8-bit character. Modes 2 and 3 are asynchronous characters that carry a ninth bit. Mode 2 runs at a fixed fraction of the system clock. Modes 1 and 3 run from an external baud tick, with sixteen ticks to each bit.

Software starts a character by writing the data buffer while the block is idle. The mode, speed selects and ninth-bit value are captured at that write, so later changes to them do not disturb a frame already under way. A sticky completion flag rises at a point that depends on the mode, and only an acknowledge pulse clears it. A busy output shows that a frame is in progress.

The control state machine has six states:
- IDLE: the line is high.
- START: the start bit is on the line.
- DATA: the data bits are on the line.
- NINTH: the ninth bit is on the line.
- STOP: the stop bit is on the line.
- SHIFT: the data bits of mode 0 are on the line.

Its transitions are:
- IDLE to SHIFT: an accepted write in mode 0.
- IDLE to START: an accepted write in any other mode.
- START to DATA: the end of a bit.
- DATA to DATA: the end of any data bit but the last.
- DATA to NINTH: the end of the last data bit in modes 2 and 3.
- DATA to STOP: the end of the last data bit in mode 1.
- NINTH to STOP: the end of a bit.
- STOP to IDLE: the end of a bit.
- SHIFT to IDLE: the end of the last data bit.

Top module: `sio_tx`

## Requirements
- R1: After reset and between frames, `txd` = 1, `sclk` = 1, `busy` = 0 and `tx_done` = 0 until a frame sets it.
- R2: Mode encoding is 00 for the shifter, 01 for the 8-bit UART, 10 for the fixed-rate 9-bit UART and 11 for the variable-rate 9-bit UART. Mode 00 sends 8 data bits, LSB first, with no start or stop bit. Mode 01 sends a 0 start bit, 8 data bits LSB first and a 1 stop bit. Modes 10 and 11 insert the ninth bit between the last data bit and the stop bit.
- R3: In mode 00 each bit lasts 12 clocks, or 6 clocks with `dbl_speed` = 1. `sclk` is low for the first half of each bit and high for the second half, which gives exactly 8 rising edges per frame.
- R4: In mode 10 each bit lasts 64 clocks with `rate_sel` = 0 and 32 clocks with `rate_sel` = 1. Setting `dbl_speed` = 1 halves both values.
- R5: In modes 01 and 11 each bit lasts 16 `baud_tick` pulses. With no ticks the frame does not advance.
- R6: The ninth bit in modes 10 and 11 equals the `bit9` value present at the accepted write.
- R7: In mode 00, `tx_done` rises at the clock edge that ends the eighth bit. In the UART modes it rises at the edge that begins the stop bit.
- R8: `tx_done` stays high until a `tx_ack` pulse clears it. A set in the same cycle as an acknowledge wins.
- R9: A write is accepted only while `busy` = 0. `busy` goes high at the edge of the accepted write and falls at the end of the last bit. A write during a frame does not change the bits sent.
- R10: `mode`, `dbl_speed`, `rate_sel` and `bit9` are captured at the accepted write. Changing them during a frame has no effect on its format, timing or ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oscillator reference for the fixed rates |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle rate pulse for modes 01 and 11 |
| mode | input | 2 | Frame format select |
| dbl_speed | input | 1 | Halves the fixed-rate bit times |
| rate_sel | input | 1 | Mode 10 rate: 0 for /64, 1 for /32 |
| bit9 | input | 1 | Ninth-bit value for modes 10 and 11 |
| wr_en | input | 1 | Data buffer write strobe |
| wr_data | input | DATA_W | Data buffer write value |
| tx_ack | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Mode 00 shift clock, idles high |
| tx_done | output | 1 | Sticky completion flag |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that `rst_n` is held low across at least one rising edge before any other activity. They also assume that inputs change only between edges. They assume nothing about how often `baud_tick` pulses, so they hold whether ticks arrive every cycle or never. The bench drives every input on the falling clock edge and asserts reset for several cycles at the start. It keeps `baud_tick` either continuously high or held low to stall a frame, which keeps the expected bit boundaries at exact clock counts.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

    typedef enum logic [1:0] {
        MD_SHIFT     = 2'b00,
        MD_UART8     = 2'b01,
        MD_UART9_FIX = 2'b10,
        MD_UART9_VAR = 2'b11
    } tx_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP,
        ST_SHIFT
    } tx_state_e;

    typedef struct packed {
        tx_mode_e mode;
        logic     dbl;
        logic     rate;
        logic     ninth;
    } tx_cfg_t;

endpackage

// File: rtl/sio_tx_pacer.sv
module sio_tx_pacer
    import sio_tx_pkg::*;
#(
    parameter int SHIFT_DIV  = 12,
    parameter int FIX_DIV    = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  tx_cfg_t cfg,
    input  logic    baud_tick,
    output logic    bit_end,
    output logic    first_half
);
    localparam int MAXA = (SHIFT_DIV > FIX_DIV) ? SHIFT_DIV : FIX_DIV;
    localparam int MAXD = (MAXA > OVERSAMPLE) ? MAXA : OVERSAMPLE;
    localparam int CW   = $clog2(MAXD + 1);

    localparam logic [CW-1:0] L_SH_N  = CW'(SHIFT_DIV);
    localparam logic [CW-1:0] L_SH_X2 = CW'(SHIFT_DIV / 2);
    localparam logic [CW-1:0] L_FX_S  = CW'(FIX_DIV);
    localparam logic [CW-1:0] L_FX_F  = CW'(FIX_DIV / 2);
    localparam logic [CW-1:0] L_VAR   = CW'(OVERSAMPLE);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [CW-1:0] fix_base;
    logic          step;

    always_comb begin
        fix_base = cfg.rate ? L_FX_F : L_FX_S;
        unique case (cfg.mode)
            MD_SHIFT: begin
                lim  = cfg.dbl ? L_SH_X2 : L_SH_N;
                step = 1'b1;
            end
            MD_UART9_FIX: begin
                lim  = cfg.dbl ? (fix_base >> 1) : fix_base;
                step = 1'b1;
            end
            default: begin
                lim  = L_VAR;
                step = baud_tick;
            end
        endcase
    end

    assign bit_end    = run && step && (cnt == lim - 1'b1);
    assign first_half = cnt < (lim >> 1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sio_tx_shifter.sv
module sio_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              shift,
    output logic              lsb,
    output logic              last_bit
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    logic [DATA_W-1:0] sreg;
    logic [IW-1:0]     idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= data_in;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {1'b0, sreg[DATA_W-1:1]};
            idx  <= idx + 1'b1;
        end
    end

    assign lsb      = sreg[0];
    assign last_bit = (idx == LAST_IDX);

endmodule

// File: rtl/sio_tx_ctrl.sv
module sio_tx_ctrl
    import sio_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  tx_cfg_t   cfg_in,
    input  logic      tx_ack,
    input  logic      bit_end,
    input  logic      first_half,
    input  logic      lsb,
    input  logic      last_bit,
    output tx_state_e state,
    output tx_cfg_t   cfg_q,
    output logic      load,
    output logic      shift,
    output logic      txd,
    output logic      sclk,
    output logic      busy,
    output logic      tx_done
);
    tx_state_e next;
    logic      nine;
    logic      set_done;

    assign load = wr_en && (state == ST_IDLE);
    assign nine = (cfg_q.mode == MD_UART9_FIX) || (cfg_q.mode == MD_UART9_VAR);

    // Next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    next = (cfg_in.mode == MD_SHIFT) ? ST_SHIFT : ST_START;
                end
            end
            ST_START: begin
                if (bit_end) next = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_bit) next = nine ? ST_NINTH : ST_STOP;
            end
            ST_NINTH: begin
                if (bit_end) next = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) next = ST_IDLE;
            end
            ST_SHIFT: begin
                if (bit_end && last_bit) next = ST_IDLE;
            end
            default: next = ST_IDLE;
        endcase
    end

    // State register and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            state <= next;
            if (load) cfg_q <= cfg_in;
        end
    end

    assign set_done = ((state == ST_DATA || state == ST_NINTH) && next == ST_STOP)
                   || (state == ST_SHIFT && next == ST_IDLE);

    // Completion flag: the set has priority over the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
        end else if (set_done) begin
            tx_done <= 1'b1;
        end else if (tx_ack) begin
            tx_done <= 1'b0;
        end
    end

    assign shift = bit_end && (state == ST_DATA || state == ST_SHIFT);

    // Outputs
    always_comb begin
        txd  = 1'b1;
        sclk = 1'b1;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_START: txd  = 1'b0;
            ST_DATA:  txd  = lsb;
            ST_NINTH: txd  = cfg_q.ninth;
            ST_STOP:  txd  = 1'b1;
            ST_SHIFT: begin
                txd  = lsb;
                sclk = !first_half;
            end
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SHIFT_DIV  = 12,
    parameter int FIX_DIV    = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [1:0]        mode,
    input  logic              dbl_speed,
    input  logic              rate_sel,
    input  logic              bit9,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_ack,
    output logic              txd,
    output logic              sclk,
    output logic              tx_done,
    output logic              busy
);
    tx_cfg_t   cfg_in;
    tx_cfg_t   cfg_q;
    tx_state_e st;
    logic      load;
    logic      shift;
    logic      bit_end;
    logic      first_half;
    logic      lsb;
    logic      last_bit;

    always_comb begin
        cfg_in.mode  = tx_mode_e'(mode);
        cfg_in.dbl   = dbl_speed;
        cfg_in.rate  = rate_sel;
        cfg_in.ninth = bit9;
    end

    sio_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .cfg_in     (cfg_in),
        .tx_ack     (tx_ack),
        .bit_end    (bit_end),
        .first_half (first_half),
        .lsb        (lsb),
        .last_bit   (last_bit),
        .state      (st),
        .cfg_q      (cfg_q),
        .load       (load),
        .shift      (shift),
        .txd        (txd),
        .sclk       (sclk),
        .busy       (busy),
        .tx_done    (tx_done)
    );

    sio_tx_pacer #(
        .SHIFT_DIV  (SHIFT_DIV),
        .FIX_DIV    (FIX_DIV),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy),
        .cfg        (cfg_q),
        .baud_tick  (baud_tick),
        .bit_end    (bit_end),
        .first_half (first_half)
    );

    sio_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data_in  (wr_data),
        .shift    (shift),
        .lsb      (lsb),
        .last_bit (last_bit)
    );

endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk
    import sio_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tx_ack,
    input logic      txd,
    input logic      sclk,
    input logic      tx_done,
    input logic      busy,
    input tx_state_e st
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && sclk));

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> !txd);

    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> txd);

    p_sclk_mode0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> (st == ST_SHIFT));

    p_flag_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (st == ST_STOP || st == ST_IDLE));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_ack) |=> tx_done);

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_START) |=> (st != ST_START));

endmodule

bind sio_tx sio_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_ack  (tx_ack),
    .txd     (txd),
    .sclk    (sclk),
    .tx_done (tx_done),
    .busy    (busy),
    .st      (st)
);

// File: tb/tb_sio_tx.sv
`timescale 1ns/1ps
module tb_sio_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [1:0] mode;
    logic       dbl_speed;
    logic       rate_sel;
    logic       bit9;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       tx_ack;
    logic       txd;
    logic       sclk;
    logic       tx_done;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int sclk_rises = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sio_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .mode      (mode),
        .dbl_speed (dbl_speed),
        .rate_sel  (rate_sel),
        .bit9      (bit9),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_ack    (tx_ack),
        .txd       (txd),
        .sclk      (sclk),
        .tx_done   (tx_done),
        .busy      (busy)
    );

    always @(posedge sclk) if (rst_n === 1'b1) sclk_rises++;

    // {intrude, mode, dbl, rate, bit9, data}
    localparam logic [13:0] VEC [0:8] = '{
        {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'hA5},
        {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 8'h3C},
        {1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 8'h81},
        {1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 8'h5A},
        {1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'hFF},
        {1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 8'h00},
        {1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 8'hC3},
        {1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 8'h6E},
        {1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 8'h17}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bit_len(input logic [1:0] m, input logic d, input logic r);
        if (m == 2'b00) return d ? 6 : 12;
        if (m == 2'b10) return (r ? 32 : 64) >> d;
        return 16;
    endfunction

    function automatic int frame_len(input logic [1:0] m);
        if (m == 2'b00) return 8;
        if (m == 2'b01) return 10;
        return 11;
    endfunction

    function automatic logic exp_bit(input logic [1:0] m, input logic b9,
                                     input logic [7:0] d, input int k);
        if (m == 2'b00) return d[k];
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (k == 9 && m[1]) return b9;
        return 1'b1;
    endfunction

    // Entered at the falling edge in the first cycle of bit 'first'
    task automatic check_bits(input logic [1:0] m, input logic d, input logic r,
                              input logic b9, input logic [7:0] data,
                              input int first, input bit intrude);
        int    len = bit_len(m, d, r);
        int    n   = frame_len(m);
        string tag;
        logic  s0, s1;
        if (m == 2'b00)      tag = "R2/R3";
        else if (m == 2'b10) tag = "R2/R4";
        else                 tag = "R2/R5";
        for (int k = first; k < n; k++) begin
            string t = tag;
            if (m != 2'b00 && k == 9 && m[1]) t = "R6";
            if (intrude && k >= 2) t = {t, "/R9/R10"};
            s0 = txd;
            if (m != 2'b00 && k == n - 1)
                check(tx_done == 1'b1, "R7 flag at stop start", tx_done, 1);
            if (intrude && k == 2) begin
                check(busy == 1'b1, "R9 busy mid-frame", busy, 1);
                wr_en     = 1'b1;
                wr_data   = ~data;
                mode      = 2'b10;
                dbl_speed = ~d;
                bit9      = ~b9;
            end
            repeat (len - 1) begin
                @(negedge clk);
                wr_en = 1'b0;
            end
            s1 = txd;
            if ((m != 2'b00 && k == n - 2) || (m == 2'b00 && k == 7))
                check(tx_done == 1'b0, "R7 flag before set point", tx_done, 0);
            check(s0 == exp_bit(m, b9, data, k) && s1 == exp_bit(m, b9, data, k),
                  t, {s0, s1}, {2{exp_bit(m, b9, data, k)}});
            @(negedge clk);
        end
        check(busy == 1'b0 && txd == 1'b1, "R1 idle after frame", {busy, txd}, 1);
        if (m == 2'b00)
            check(tx_done == 1'b1, "R7 flag at end of eighth bit", tx_done, 1);
        check(sclk_rises == ((m == 2'b00) ? 8 : 0), "R3 shift clock edges",
              sclk_rises, (m == 2'b00) ? 8 : 0);
    endtask

    task automatic start_frame(input logic [1:0] m, input logic d, input logic r,
                               input logic b9, input logic [7:0] data);
        mode       = m;
        dbl_speed  = d;
        rate_sel   = r;
        bit9       = b9;
        wr_data    = data;
        wr_en      = 1'b1;
        sclk_rises = 0;
        @(negedge clk);
        wr_en = 1'b0;
        check(busy == 1'b1, "R9 busy after write", busy, 1);
    endtask

    task automatic ack_flag();
        repeat (5) @(negedge clk);
        check(tx_done == 1'b1, "R8 flag sticky", tx_done, 1);
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
        check(tx_done == 1'b0, "R8 ack clears flag", tx_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        baud_tick = 1'b1;
        mode      = 2'b00;
        dbl_speed = 1'b0;
        rate_sel  = 1'b0;
        bit9      = 1'b0;
        wr_en     = 1'b0;
        wr_data   = 8'h00;
        tx_ack    = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(txd == 1'b1 && sclk == 1'b1 && busy == 1'b0 && tx_done == 1'b0,
              "R1 reset state", {txd, sclk, busy, tx_done}, 4'b1100);

        // Table of frames
        for (int i = 0; i < 9; i++) begin
            logic [13:0] v = VEC[i];
            start_frame(v[12:11], v[10], v[9], v[8], v[7:0]);
            check_bits(v[12:11], v[10], v[9], v[8], v[7:0], 0, v[13]);
            ack_flag();
        end

        // R5: no ticks means no progress
        baud_tick = 1'b0;
        start_frame(2'b01, 1'b0, 1'b0, 1'b0, 8'h96);
        repeat (200) @(negedge clk);
        check(txd == 1'b0 && busy == 1'b1, "R5 stalled start bit", {txd, busy}, 2'b01);
        baud_tick = 1'b1;
        repeat (16) @(negedge clk);
        check_bits(2'b01, 1'b0, 1'b0, 1'b0, 8'h96, 1, 1'b0);
        ack_flag();

        // R9: write while idle after a frame is accepted again at once
        start_frame(2'b00, 1'b1, 1'b0, 1'b0, 8'h01);
        check_bits(2'b00, 1'b1, 1'b0, 1'b0, 8'h01, 0, 1'b0);
        ack_flag();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule